// File: doc/BRIEF.md
# DMA Channel Job Controller

This block is the register-facing half of a single DMA channel. Software programs a job through a small word-indexed register bus: a source address, a destination address, a length in 32-bit words, and a flow word that holds the transfer direction and the memory or peripheral mode. A write-one command register starts or clears the job. The block presents the job to a separate data mover and raises a request. It tracks whether the job is armed and whether the mover has taken it. It counts the words left on the read side and on the write side from per-word progress pulses.

Software does not see the remaining-word counts live. A read of the status register captures the read-side count into the read data and captures the write-side count into a companion register in the same cycle. Both values therefore describe the same instant. Job parameters are frozen from an accepted start until a clear. The end of a job leaves a code and, for bus errors, the failing side. These stay visible together with a level interrupt.

The register index map is: 0 source, 1 destination, 2 length, 3 flow, 4 command, 5 status, 6 write-left snapshot, 7 end/interrupt. Read data appears on the cycle after the read strobe.

Top module: `dma_jobctl`

## Requirements
- R1: Addresses written to index 0 (source) and 1 (destination) are stored with bits 1:0 forced to zero. All registers read as zero after reset.
- R2: The length register (index 2) keeps only its low 18 bits, a word count of up to 256K words. Higher write bits are dropped.
- R3: Writing bit 0 of the command register (index 4) while idle with a nonzero length sets the active flag (status bit 0) and raises `mv_req`. The in-progress flag (status bit 4) is set only by an `mv_ack` pulse, which also drops `mv_req`.
- R4: While active, writes to indices 0 to 3 are ignored.
- R5: Writing bit 1 of the command register ends any job and zeroes source, destination, length, flow, both counts, the flags, the end code and `irq`. A clear wins over a start written in the same word.
- R6: An accepted start loads both counts with the length. Each `mv_rd_beat`/`mv_wr_beat` pulse during in-progress decrements its count. When both reach zero the job ends: the flags drop, `irq` rises and the end code (index 7 bits 1:0) is 0.
- R7: Status bits 27:8 return the read-left count at the moment of the status read. The same read copies the write-left count into index 6 bits 27:8, which otherwise does not change.
- R8: An `mv_err` pulse during in-progress ends the job with end code 1. Bit 2 of index 7 is `mv_err_side` (0 source bus, 1 destination bus).
- R9: A start with a length of zero ends at once with end code 0 and `irq` high, without raising `mv_req`.
- R10: `irq` (also index 7 bit 3) is a level that holds from job end until a clear or the next accepted start.
- R11: A start written while active is ignored; counts and flags keep their values.
- R12: Flow register (index 3) bit 0 is direction (0 inbound from external memory, 1 outbound to it) and bit 1 is mode (0 memory, 1 peripheral). Both drive `mv_dir` and `mv_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd_en` |
| mv_req | output | 1 | Job armed and waiting for the mover |
| mv_ack | input | 1 | Mover takes the job (pulse) |
| mv_rd_beat | input | 1 | One word read by the mover (pulse) |
| mv_wr_beat | input | 1 | One word written by the mover (pulse) |
| mv_err | input | 1 | Bus error seen by the mover (pulse) |
| mv_err_side | input | 1 | Side of the error: 0 source, 1 destination |
| mv_src | output | 32 | Job source address |
| mv_dst | output | 32 | Job destination address |
| mv_len | output | 18 | Job length in words |
| mv_dir | output | 1 | Transfer direction |
| mv_mode | output | 1 | Memory or peripheral mode |
| irq | output | 1 | Level job-end interrupt |

## Verification
A wrong count or a lost beat appears in status bits 27:8 on the very next status read. It also shows up as a missing or early `irq`, because completion depends on both counts reaching zero together. A snapshot that updates on the wrong event shows up as a changed write-left register between two status reads, one register-read latency after the stray update. A broken lock or clear shows up at `mv_src`, `mv_dst` and `mv_len` in the cycle after the offending write. Flag errors show up on `mv_req` in that same cycle.

// File: rtl/dma_jobctl_pkg.sv
package dma_jobctl_pkg;

    localparam int REG_IDX_W     = 3;
    localparam int CNT_FIELD_W   = 20;
    localparam int CNT_FIELD_LSB = 8;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_CLEAR_BIT = 1;
    localparam int ST_ACTIVE_BIT = 0;
    localparam int ST_BUSY_BIT   = 4;
    localparam int IRQ_SIDE_BIT  = 2;
    localparam int IRQ_LVL_BIT   = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        RI_SRC   = 3'd0,
        RI_DST   = 3'd1,
        RI_LEN   = 3'd2,
        RI_FLOW  = 3'd3,
        RI_CMD   = 3'd4,
        RI_STAT  = 3'd5,
        RI_WLEFT = 3'd6,
        RI_END   = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        END_DONE   = 2'd0,
        END_BUSERR = 2'd1
    } end_code_e;

    typedef struct packed {
        end_code_e code;
        logic      side;
    } end_info_t;

    typedef struct packed {
        logic mode;
        logic dir;
    } flow_t;

    function automatic logic [31:0] count_field(input logic [CNT_FIELD_W-1:0] c);
        logic [31:0] r;
        r = '0;
        r[CNT_FIELD_LSB +: CNT_FIELD_W] = c;
        return r;
    endfunction

endpackage

// File: rtl/dma_jobctl_regs.sv
module dma_jobctl_regs
    import dma_jobctl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_idx_e          wr_idx,
    input  logic [31:0]       wdata,
    input  logic              lock,
    input  logic              wipe,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [LEN_W-1:0]  len,
    output flow_t             flow
);
    localparam int ALIGN_BITS = 2;

    logic wr_ok;
    assign wr_ok = wr_en && !lock;

    // word alignment is enforced by dropping the low address bits
    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            src  <= '0;
            dst  <= '0;
            len  <= '0;
            flow <= '0;
        end else if (wr_ok) begin
            case (wr_idx)
                RI_SRC:  src  <= {wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                RI_DST:  dst  <= {wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                RI_LEN:  len  <= wdata[LEN_W-1:0];
                RI_FLOW: flow <= flow_t'(wdata[1:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_jobctl_wcnt.sv
module dma_jobctl_wcnt #(
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             beat,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] cnt_nxt
);
    always_comb begin
        if (wipe)
            cnt_nxt = '0;
        else if (load)
            cnt_nxt = load_val;
        else if (beat && (cnt != '0))
            cnt_nxt = cnt - 1'b1;
        else
            cnt_nxt = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

endmodule

// File: rtl/dma_jobctl_seq.sv
module dma_jobctl_seq
    import dma_jobctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_cmd,
    input  logic      clear_cmd,
    input  logic      len_zero,
    input  logic      all_zero_nxt,
    input  logic      mv_ack,
    input  logic      mv_err,
    input  logic      mv_err_side,
    output logic      active,
    output logic      busy,
    output logic      irq,
    output end_info_t info,
    output logic      load,
    output logic      mv_req
);
    logic accept;
    assign accept = start_cmd && !active && !clear_cmd;
    assign load   = accept;
    assign mv_req = active && !busy;

    always_ff @(posedge clk) begin
        if (rst || clear_cmd) begin
            active <= 1'b0;
            busy   <= 1'b0;
            irq    <= 1'b0;
            info   <= '0;
        end else if (accept) begin
            info.code <= END_DONE;
            info.side <= 1'b0;
            if (len_zero) begin
                irq <= 1'b1;
            end else begin
                active <= 1'b1;
                irq    <= 1'b0;
            end
        end else if (busy && mv_err) begin
            active    <= 1'b0;
            busy      <= 1'b0;
            irq       <= 1'b1;
            info.code <= END_BUSERR;
            info.side <= mv_err_side;
        end else if (busy && all_zero_nxt) begin
            active    <= 1'b0;
            busy      <= 1'b0;
            irq       <= 1'b1;
            info.code <= END_DONE;
            info.side <= 1'b0;
        end else if (mv_req && mv_ack) begin
            busy <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_jobctl_rdmux.sv
module dma_jobctl_rdmux
    import dma_jobctl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_idx_e          rd_idx,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [LEN_W-1:0]  len,
    input  flow_t             flow,
    input  logic              active,
    input  logic              busy,
    input  logic              irq,
    input  end_info_t         info,
    input  logic [LEN_W-1:0]  rd_cnt,
    input  logic [LEN_W-1:0]  wr_cnt,
    output logic [31:0]       rdata
);
    logic [LEN_W-1:0] snap_wr;
    logic [31:0]      stat_word;
    logic [31:0]      end_word;
    logic [31:0]      sel;
    logic             snap_en;

    assign snap_en = rd_en && (rd_idx == RI_STAT);

    always_comb begin
        stat_word = count_field(CNT_FIELD_W'(rd_cnt));
        stat_word[ST_ACTIVE_BIT] = active;
        stat_word[ST_BUSY_BIT]   = busy;
        end_word = '0;
        end_word[1:0]          = info.code;
        end_word[IRQ_SIDE_BIT] = info.side;
        end_word[IRQ_LVL_BIT]  = irq;
    end

    always_comb begin
        case (rd_idx)
            RI_SRC:   sel = 32'(src);
            RI_DST:   sel = 32'(dst);
            RI_LEN:   sel = 32'(len);
            RI_FLOW:  sel = 32'(flow);
            RI_STAT:  sel = stat_word;
            RI_WLEFT: sel = count_field(CNT_FIELD_W'(snap_wr));
            RI_END:   sel = end_word;
            default:  sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_wr <= '0;
            rdata   <= '0;
        end else begin
            if (snap_en)
                snap_wr <= wr_cnt;
            if (rd_en)
                rdata <= sel;
        end
    end

endmodule

// File: rtl/dma_jobctl.sv
module dma_jobctl
    import dma_jobctl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic                 reg_rd_en,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 mv_req,
    input  logic                 mv_ack,
    input  logic                 mv_rd_beat,
    input  logic                 mv_wr_beat,
    input  logic                 mv_err,
    input  logic                 mv_err_side,
    output logic [ADDR_W-1:0]    mv_src,
    output logic [ADDR_W-1:0]    mv_dst,
    output logic [LEN_W-1:0]     mv_len,
    output logic                 mv_dir,
    output logic                 mv_mode,
    output logic                 irq
);
    localparam int NSIDE = 2;

    reg_idx_e  idx;
    logic      cmd_wr, start_cmd, clear_cmd;
    logic      active_q, busy_q, load;
    end_info_t info;
    flow_t     flow;
    logic [LEN_W-1:0] cnt_q [NSIDE];
    logic [LEN_W-1:0] cnt_n [NSIDE];
    logic [NSIDE-1:0] beats;
    logic             all_zero_nxt;

    assign idx       = reg_idx_e'(reg_idx);
    assign cmd_wr    = reg_wr_en && (idx == RI_CMD);
    assign start_cmd = cmd_wr && reg_wdata[CMD_START_BIT];
    assign clear_cmd = cmd_wr && reg_wdata[CMD_CLEAR_BIT];
    assign beats     = {mv_wr_beat, mv_rd_beat} & {NSIDE{busy_q}};

    dma_jobctl_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_idx(idx),
        .wdata(reg_wdata), .lock(active_q), .wipe(clear_cmd),
        .src(mv_src), .dst(mv_dst), .len(mv_len), .flow(flow)
    );

    assign mv_dir  = flow.dir;
    assign mv_mode = flow.mode;

    // index 0 counts read-side words, index 1 write-side words
    for (genvar g = 0; g < NSIDE; g++) begin : g_cnt
        dma_jobctl_wcnt #(.LEN_W(LEN_W)) cnt_i (
            .clk(clk), .rst(rst), .wipe(clear_cmd), .load(load),
            .load_val(mv_len), .beat(beats[g]),
            .cnt(cnt_q[g]), .cnt_nxt(cnt_n[g])
        );
    end

    assign all_zero_nxt = (cnt_n[0] == '0) && (cnt_n[1] == '0);

    dma_jobctl_seq seq_i (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .clear_cmd(clear_cmd),
        .len_zero(mv_len == '0), .all_zero_nxt(all_zero_nxt),
        .mv_ack(mv_ack), .mv_err(mv_err), .mv_err_side(mv_err_side),
        .active(active_q), .busy(busy_q), .irq(irq), .info(info),
        .load(load), .mv_req(mv_req)
    );

    dma_jobctl_rdmux #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) rdmux_i (
        .clk(clk), .rst(rst), .rd_en(reg_rd_en), .rd_idx(idx),
        .src(mv_src), .dst(mv_dst), .len(mv_len), .flow(flow),
        .active(active_q), .busy(busy_q), .irq(irq), .info(info),
        .rd_cnt(cnt_q[0]), .wr_cnt(cnt_q[1]), .rdata(reg_rdata)
    );

endmodule

// File: rtl/dma_jobctl_chk.sv
module dma_jobctl_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [2:0]        reg_idx,
    input logic [31:0]       reg_wdata,
    input logic              mv_req,
    input logic              mv_ack,
    input logic [ADDR_W-1:0] mv_src,
    input logic [ADDR_W-1:0] mv_dst,
    input logic [LEN_W-1:0]  mv_len,
    input logic              irq,
    input logic              active,
    input logic              busy
);
    logic cmd_w, st_w, cl_w;
    assign cmd_w = reg_wr_en && (reg_idx == 3'd4);
    assign st_w  = cmd_w && reg_wdata[0];
    assign cl_w  = cmd_w && reg_wdata[1];

    p_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        (mv_src[1:0] == 2'b00) && (mv_dst[1:0] == 2'b00));

    p_req_when_armed_r3: assert property (@(posedge clk) disable iff (rst)
        mv_req |-> (active && !busy));

    p_ack_takes_r3: assert property (@(posedge clk) disable iff (rst)
        (mv_req && mv_ack && !cmd_w) |=> busy);

    p_locked_r4: assert property (@(posedge clk) disable iff (rst)
        active |=> (!active || ($stable(mv_src) && $stable(mv_dst) && $stable(mv_len))));

    p_clear_wipes_r5: assert property (@(posedge clk) disable iff (rst)
        cl_w |=> (!active && !irq && !mv_req && (mv_len == '0)));

    p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
        (st_w && !cl_w && !active && (mv_len == '0)) |=> (irq && !mv_req));

    p_irq_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !st_w && !cl_w) |=> irq);

endmodule

bind dma_jobctl dma_jobctl_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .mv_req(mv_req), .mv_ack(mv_ack),
    .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len), .irq(irq),
    .active(active_q), .busy(busy_q)
);

// File: tb/dma_jobctl_tb_top.sv
`timescale 1ns/1ps
module dma_jobctl_tb_top;
    localparam int I_SRC = 0, I_DST = 1, I_LEN = 2, I_FLOW = 3;
    localparam int I_CMD = 4, I_STAT = 5, I_WL = 6, I_END = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 0, reg_rd_en = 0;
    logic [2:0]  reg_idx = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        mv_req, mv_ack = 0, mv_rd_beat = 0, mv_wr_beat = 0;
    logic        mv_err = 0, mv_err_side = 0;
    logic [31:0] mv_src, mv_dst;
    logic [17:0] mv_len;
    logic        mv_dir, mv_mode, irq;

    int total = 0, bad = 0;
    int e_rd = 0, e_wr = 0, e_snap = 0;

    always #5 clk = ~clk;

    dma_jobctl dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mv_req(mv_req), .mv_ack(mv_ack), .mv_rd_beat(mv_rd_beat),
        .mv_wr_beat(mv_wr_beat), .mv_err(mv_err), .mv_err_side(mv_err_side),
        .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len), .mv_dir(mv_dir),
        .mv_mode(mv_mode), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_idx = 3'(idx); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1; reg_idx = 3'(idx);
        @(negedge clk);
        reg_rd_en = 0;
        d = reg_rdata;
    endtask

    task automatic stat(input string req, input int act, input int bsy);
        logic [31:0] d;
        rd(I_STAT, d);
        chk(req, d, (32'(e_rd) << 8) | (32'(bsy) << 4) | 32'(act));
        e_snap = e_wr;
    endtask

    task automatic pulse(input logic a, input logic r, input logic w, input logic e, input logic s);
        @(negedge clk);
        mv_ack = a; mv_rd_beat = r; mv_wr_beat = w; mv_err = e; mv_err_side = s;
        @(negedge clk);
        mv_ack = 0; mv_rd_beat = 0; mv_wr_beat = 0; mv_err = 0; mv_err_side = 0;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(i, d); chk("R1 reset read", d, 0);
        end
        chk("R1 reset irq", 32'(irq), 0);
        wr(I_SRC, 32'h1234_5677); rd(I_SRC, d); chk("R1 src align", d, 32'h1234_5674);
        wr(I_DST, 32'hFFFF_FFFF); rd(I_DST, d); chk("R1 dst align", d, 32'hFFFF_FFFC);
        chk("R1 port src", mv_src, 32'h1234_5674);
        wr(I_LEN, 32'hFFFF_FFFF); rd(I_LEN, d); chk("R2 len width", d, 32'h0003_FFFF);
        wr(I_FLOW, 32'h3); rd(I_FLOW, d); chk("R12 flow read", d, 3);
        chk("R12 dir/mode", {30'b0, mv_mode, mv_dir}, 3);
        wr(I_FLOW, 32'h6); rd(I_FLOW, d); chk("R12 flow bits", d, 2);
        chk("R12 dir/mode", {30'b0, mv_mode, mv_dir}, 2);
        wr(I_SRC, 32'h100);

        for (int L = 1; L <= 5; L++) begin
            for (int p = 0; p < 2; p++) begin
                wr(I_LEN, 32'(L));
                wr(I_CMD, 32'h1);
                e_rd = L; e_wr = L;
                chk("R3 req raised", 32'(mv_req), 1);
                chk("R10 irq drop on start", 32'(irq), 0);
                stat("R3 armed status", 1, 0);
                pulse(1, 0, 0, 0, 0);
                chk("R3 req dropped", 32'(mv_req), 0);
                stat("R3 in progress", 1, 1);
                wr(I_SRC, 32'hABC0); rd(I_SRC, d); chk("R4 src locked", d, 32'h100);
                wr(I_LEN, 32'd77); rd(I_LEN, d); chk("R4 len locked", d, 32'(L));
                if (p == 0) begin
                    for (int i = 0; i < L; i++) begin
                        pulse(0, 1, 0, 0, 0);
                        e_rd--;
                        rd(I_WL, d); chk("R7 snapshot held", d, 32'(e_snap) << 8);
                        stat("R6 rd count", 1, 1);
                        rd(I_WL, d); chk("R7 snapshot taken", d, 32'(e_wr) << 8);
                    end
                    wr(I_CMD, 32'h1);
                    stat("R11 start while active", 1, 1);
                    for (int i = 0; i < L; i++) begin
                        pulse(0, 0, 1, 0, 0);
                        e_wr--;
                        if (e_wr > 0) begin
                            chk("R6 no early irq", 32'(irq), 0);
                            stat("R6 wr phase", 1, 1);
                        end
                    end
                end else begin
                    for (int i = 0; i < L; i++) begin
                        pulse(0, 1, 1, 0, 0);
                        e_rd--; e_wr--;
                        if (e_wr > 0) stat("R6 joint beats", 1, 1);
                    end
                end
                chk("R6 irq at end", 32'(irq), 1);
                stat("R6 idle after end", 0, 0);
                rd(I_WL, d); chk("R7 wr snapshot zero", d, 0);
                rd(I_END, d); chk("R6 end code done", d, 32'h8);
                repeat (3) @(negedge clk);
                chk("R10 irq held", 32'(irq), 1);
            end
        end

        // R10 next start clears irq, then R5 clear mid-job
        wr(I_LEN, 32'd2); wr(I_CMD, 32'h1);
        chk("R10 irq cleared by start", 32'(irq), 0);
        pulse(1, 0, 0, 0, 0);
        pulse(0, 1, 0, 0, 0);
        wr(I_CMD, 32'h2);
        e_rd = 0; e_wr = 0;
        stat("R5 status cleared", 0, 0);
        rd(I_SRC, d); chk("R5 src wiped", d, 0);
        rd(I_LEN, d); chk("R5 len wiped", d, 0);
        rd(I_END, d); chk("R5 end wiped", d, 0);
        chk("R5 req low", 32'(mv_req), 0);
        wr(I_LEN, 32'd3); wr(I_CMD, 32'h3);
        stat("R5 clear beats start", 0, 0);
        rd(I_LEN, d); chk("R5 len wiped by combined", d, 0);

        // R8 bus errors on each side
        wr(I_LEN, 32'd4); wr(I_CMD, 32'h1);
        pulse(1, 0, 0, 0, 0);
        pulse(0, 1, 0, 0, 0);
        pulse(0, 0, 0, 1, 1);
        chk("R8 irq on error", 32'(irq), 1);
        rd(I_END, d); chk("R8 dest error", d, 32'hD);
        e_rd = 3; e_wr = 4;
        stat("R8 job ended", 0, 0);
        wr(I_CMD, 32'h1);
        pulse(1, 0, 0, 0, 0);
        pulse(0, 0, 0, 1, 0);
        rd(I_END, d); chk("R8 source error", d, 32'h9);

        // R9 zero length
        wr(I_CMD, 32'h2);
        wr(I_CMD, 32'h1);
        chk("R9 irq at once", 32'(irq), 1);
        chk("R9 no request", 32'(mv_req), 0);
        rd(I_END, d); chk("R9 done code", d, 32'h8);
        e_rd = 0; e_wr = 0;
        stat("R9 status idle", 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule